// File: doc/BRIEF.md
# Audio Transmit FIFO Register Block

This block sits between a processor bus and an audio serializer. Software writes stereo samples as pairs of 32-bit words to a data register, left then right. The block queues them in a first-in first-out buffer, and the serializer drains them one word at a time. A small bank of word-aligned registers holds a build constant, the serializer configuration, an interrupt mask and a live interrupt status. The register decode uses only address bits 4:2.

The status has two conditions and both are recomputed every cycle from the queue occupancy. The underrun condition means the queue is empty. The level condition means the occupancy has fallen under a threshold. That threshold starts at half the queue depth and is halved once for each step of a 4-bit code in the configuration. The single interrupt line is raised while the global interrupt enable is set and some unmasked status condition is true. Software typically refills the queue on a level interrupt. It keeps an underrun interrupt as a last-resort signal that playback has stalled.

Top module: `audio_tx_regs`

## Requirements
- R1: After reset the configuration and mask read as zero, the queue is empty, ser_valid is 0, irq is 0 and the status reads 0x1 (underrun only, since level code 0 gives a zero threshold).
- R2: Offset 0x00 reads the VERSION parameter (default 0x00010003), and writes to it have no effect.
- R3: Offset 0x04 stores the write data masked with 0xFF3FFF07 and reads it back. Bit 0 drives cfg_tx_en, bit 1 is the interrupt enable, bit 2 drives cfg_left, bits 15:8 drive cfg_ratio, bits 21:16 drive cfg_res, bits 27:24 are the level code and bits 31:28 drive cfg_chan.
- R4: Offset 0x08 stores bits 1:0 of the write data as the interrupt mask, and the other bits read zero.
- R5: A write to offset 0x10 appends the word to the queue. ser_data always shows the oldest word, and a ser_pop while the queue is non-empty removes it, so words leave in write order.
- R6: Writes to 0x14, 0x18 and 0x1C are ignored. Reads of 0x10 to 0x1C return zero.
- R7: A write to 0x10 while the queue holds DEPTH words is dropped, and the words already queued are unchanged.
- R8: A ser_pop while the queue is empty is ignored and the queue stays empty.
- R9: Status bit 0 (underrun) reads 1 exactly when the queue is empty. ser_valid is its inverse.
- R10: Status bit 1 (level) reads 1 exactly when the occupancy is below the threshold. The threshold is 0 for level code 0 and (DEPTH/2) >> (code-1) for codes 1 to 15.
- R11: Writes to the status offset 0x0C have no effect on the status read back.
- R12: irq equals config bit 1 AND the OR of (status & mask).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte address; bits 4:2 pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| ser_pop | input | 1 | Serializer takes the head word |
| ser_data | output | 32 | Head word of the queue |
| ser_valid | output | 1 | Queue holds at least one word |
| cfg_tx_en | output | 1 | Transmit enable |
| cfg_left | output | 1 | Left-channel flag |
| cfg_ratio | output | 8 | Clock divide ratio |
| cfg_res | output | 6 | Sample resolution |
| cfg_chan | output | 4 | Channel field |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the queue past its depth. A design that wrapped its write pointer would overwrite the oldest samples, and the pop order would then show foreign words where the first ones belong. It pops an empty queue, which a design without a guard would turn into a count that wraps to full. It sweeps every level code at a fixed occupancy, including an occupancy equal to a threshold, where a design using "at or below" instead of "below" sets the level bit one word early. The random phase then mixes pushes, pops, mask and enable changes, and writes of ones to the status offset. A status register that latched or cleared on write would disagree with the occupancy-derived model, and so would the interrupt it drives.

// File: rtl/audio_tx_regs.sv
module audio_tx_regs #(
  parameter int          DEPTH   = 256,
  parameter logic [31:0] VERSION = 32'h0001_0003
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ser_pop,
  output logic [31:0] ser_data,
  output logic        ser_valid,
  output logic        cfg_tx_en,
  output logic        cfg_left,
  output logic [7:0]  cfg_ratio,
  output logic [5:0]  cfg_res,
  output logic [3:0]  cfg_chan,
  output logic        irq
);

  localparam int          PW       = $clog2(DEPTH);
  localparam int          CW       = PW + 1;
  localparam logic [CW-1:0] FULL   = CW'(DEPTH);
  localparam logic [CW-1:0] HALF   = CW'(DEPTH / 2);
  localparam logic [31:0] CFG_KEEP = 32'hFF3F_FF07;

  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt, thresh;
  logic [31:0]   cfg;
  logic [1:0]    mask, status;

  wire [2:0] idx   = bus_addr[4:2];
  wire       wr_en = bus_sel & bus_wr;
  wire       push  = wr_en && idx == 3'd4 && cnt != FULL;
  wire       pop   = ser_pop && cnt != '0;
  wire [3:0] code  = cfg[27:24];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg  <= '0;
      mask <= '0;
    end else if (wr_en) begin
      if (idx == 3'd1) cfg  <= bus_wdata & CFG_KEEP;
      if (idx == 3'd2) mask <= bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_comb begin
    if (code == 4'd0) thresh = '0;
    else              thresh = HALF >> (code - 4'd1);
  end

  assign status    = {cnt < thresh, cnt == '0};
  assign irq       = cfg[1] & |(status & mask);
  assign ser_data  = mem[rp];
  assign ser_valid = cnt != '0;
  assign cfg_tx_en = cfg[0];
  assign cfg_left  = cfg[2];
  assign cfg_ratio = cfg[15:8];
  assign cfg_res   = cfg[21:16];
  assign cfg_chan  = cfg[31:28];

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (idx)
        3'd0:    bus_rdata = VERSION;
        3'd1:    bus_rdata = cfg;
        3'd2:    bus_rdata = {30'd0, mask};
        3'd3:    bus_rdata = {30'd0, status};
        default: bus_rdata = '0;
      endcase
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL && !ser_pop) |=> cnt == FULL && $stable(wp));
  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !(wr_en && idx == 3'd4)) |=> cnt == '0 && $stable(rp));
  assert_pop_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_pop && cnt != '0 && !wr_en) |=> cnt == $past(cnt) - 1'b1 && rp == $past(rp) + 1'b1);
  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && idx == 3'd1) |=> $stable(cfg));
  assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && idx == 3'd2) |=> $stable(mask));

endmodule

// File: tb/audio_tx_regs_test.sv
module audio_tx_regs_test;
  localparam int DEPTH = 256;

  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0, ser_pop = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, ser_data;
  logic        ser_valid, cfg_tx_en, cfg_left, irq;
  logic [7:0]  cfg_ratio;
  logic [5:0]  cfg_res;
  logic [3:0]  cfg_chan;

  int checks = 0, errors = 0;
  logic [31:0] q[$];
  logic [31:0] m_cfg = '0;
  logic [1:0]  m_mask = '0;

  always #4 clk = ~clk;

  audio_tx_regs #(.DEPTH(DEPTH)) uut (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .ser_pop, .ser_data, .ser_valid, .cfg_tx_en, .cfg_left, .cfg_ratio,
    .cfg_res, .cfg_chan, .irq);

  function automatic int thr(input logic [3:0] c);
    return (c == 0) ? 0 : ((DEPTH / 2) >> (c - 1));
  endfunction

  function automatic logic [31:0] exp_status(input int n, input logic [3:0] c);
    return {30'd0, n < thr(c), n == 0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    if (a[4:2] == 3'd1) m_cfg = d & 32'hFF3F_FF07;
    if (a[4:2] == 3'd2) m_mask = d[1:0];
    if (a[4:2] == 3'd4 && q.size() < DEPTH) q.push_back(d);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 v = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic pop_one();
    @(negedge clk);
    if (q.size() > 0) chk("R5 head", ser_data, q[0]);
    ser_pop = 1;
    @(negedge clk);
    ser_pop = 0;
    if (q.size() > 0) void'(q.pop_front());
  endtask

  task automatic chk_state(input string tag);
    logic [31:0] v;
    logic [31:0] es;
    es = exp_status(q.size(), m_cfg[27:24]);
    rd(5'h0C, v);
    chk({"R9 R10 status ", tag}, v, es);
    chk({"R12 irq ", tag}, {31'd0, irq}, {31'd0, m_cfg[1] & |(es[1:0] & m_mask)});
    chk({"R9 valid ", tag}, {31'd0, ser_valid}, {31'd0, q.size() != 0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(5'h04, v); chk("R1 cfg", v, 0);
    rd(5'h08, v); chk("R1 mask", v, 0);
    rd(5'h0C, v); chk("R1 status", v, 32'h1);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 valid", {31'd0, ser_valid}, 0);

    // R2 version
    rd(5'h00, v); chk("R2 version", v, 32'h0001_0003);
    wr(5'h00, 32'hDEAD_BEEF);
    rd(5'h00, v); chk("R2 version after write", v, 32'h0001_0003);

    // R3 config and outputs
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, v); chk("R3 cfg readback", v, 32'hFF3F_FF07);
    wr(5'h04, 32'h5A2B_C705);
    rd(5'h04, v); chk("R3 cfg readback2", v, 32'h5A2B_C705 & 32'hFF3F_FF07);
    chk("R3 fields", {cfg_chan, cfg_res, cfg_ratio, cfg_left, cfg_tx_en},
        {4'h5, 6'h2B, 8'hC7, 1'b1, 1'b1});

    // R4 mask
    wr(5'h08, 32'hFFFF_FFFE);
    rd(5'h08, v); chk("R4 mask", v, 32'h2);

    // R6 other data offsets ignored, data offsets read zero
    wr(5'h04, 32'h0);
    wr(5'h14, 32'h1111); wr(5'h18, 32'h2222); wr(5'h1C, 32'h3333);
    chk("R6 ignored writes", {31'd0, ser_valid}, 0);
    for (int a = 4; a < 8; a++) begin
      rd(5'(a * 4), v); chk("R6 data read zero", v, 0);
    end

    // R8 pop empty
    pop_one();
    chk("R8 pop empty", {31'd0, ser_valid}, 0);
    wr(5'h10, 32'hA5A5_0001);
    chk("R8 single word head", ser_data, 32'hA5A5_0001);
    pop_one();
    chk("R8 empty after pop", {31'd0, ser_valid}, 0);

    // R7 fill beyond depth
    for (int i = 0; i < DEPTH + 4; i++) wr(5'h10, 32'hC000_0000 + i);
    chk("R7 count stays full", 32'(q.size()), DEPTH);
    chk("R7 still valid", {31'd0, ser_valid}, 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R7 R5 order", ser_data, 32'hC000_0000 + i);
      pop_one();
    end
    chk("R7 drained", {31'd0, ser_valid}, 0);

    // R11 status write ignored
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, v); chk("R11 status after write", v, 32'h1);

    // R10 threshold sweep at occupancy 32 and 31
    for (int i = 0; i < 32; i++) wr(5'h10, $urandom);
    for (int c = 0; c < 16; c++) begin
      wr(5'h04, 32'(c) << 24);
      rd(5'h0C, v); chk("R10 sweep 32", v, exp_status(32, 4'(c)));
    end
    pop_one();
    wr(5'h04, 32'h0300_0000);
    rd(5'h0C, v); chk("R10 below threshold", v, 32'h2);

    // R12 irq gating
    wr(5'h08, 32'h2);
    chk("R12 irq disabled", {31'd0, irq}, 0);
    wr(5'h04, 32'h0300_0002);
    chk("R12 irq level", {31'd0, irq}, 1);
    wr(5'h08, 32'h1);
    chk("R12 irq masked", {31'd0, irq}, 0);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 40)      wr(5'h10, $urandom);
      else if (r < 75) pop_one();
      else if (r < 82) wr(5'h04, {$urandom_range(0, 15) & 32'hF, 4'($urandom_range(0, 8)),
                                   24'($urandom) & 24'h3FFF07});
      else if (r < 88) wr(5'h08, $urandom);
      else if (r < 93) wr(5'h0C, 32'h3);
      else             wr(5'(4 * $urandom_range(5, 7)), $urandom);
      if (n % 3 == 0) chk_state("random");
    end
    chk_state("final");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule